// File: doc/BRIEF.md
# Byte-Level SPI Slave Front End with Hold

This block is the pin-facing layer of a serial memory slave. It runs entirely on a fast system clock that oversamples the serial pins: the serial clock, the data input, the active-low select and the active-low hold request each pass through a two-flop synchronizer. Edges of the serial clock are then found in the system clock domain. Both serial clock polarities are accepted, so the bus may idle with the clock low or with the clock high. Data moves most significant bit first in both directions. Input bits are sampled on serial clock rises, and the output bit changes only after serial clock falls.

Each time eight bits have been sampled, the block raises a one-cycle strobe and presents the received byte to the command layer. The command layer supplies the next byte to send on `tx_byte_i`. That byte is captured when the select goes active, and again at the first falling serial clock edge after each completed byte. If the select is released part-way through a byte, the frame is abandoned with a one-cycle abort pulse and the bit position returns to zero.

The hold request pauses a frame without losing the bit position. Hold engages and releases only while the serial clock is low. A request edge seen while the clock is high takes effect at the next low phase. While held, clock and data edges are ignored and the output driver is switched off. Releasing the select during hold clears the hold and the framing state.

Top module: `sfe_spi_frontend`

## Requirements
- R1: After reset, `so_oe_o`, `rx_valid_o`, `frame_start_o` and `abort_o` are all 0.
- R2: With the clock idling low, eight sampled bits are assembled MSB first into `rx_byte_o`, and `rx_valid_o` is high for exactly one system clock per byte.
- R3: With the clock idling high, the first falling clock edge after select does not move the output. Reception and transmission then match the idle-low case.
- R4: `tx_byte_i` is captured when select goes low and again at the first falling clock edge after each completed byte. `so_o` presents it MSB first and changes only after falling edges.
- R5: `frame_start_o` pulses for one system clock after each high-to-low transition of the select.
- R6: Releasing the select after 1 to 7 bits of a byte gives a one-cycle `abort_o` and no `rx_valid_o`. The next frame starts again at bit 7.
- R7: A hold request made while the clock is low stops the drive on `so_oe_o`. Clock and data edges during hold change neither the received bits nor the output position.
- R8: A hold request that arrives while the clock is high takes effect only once the clock is low.
- R9: A hold release that arrives while the clock is high takes effect only once the clock is low.
- R10: Releasing the select during hold ends the hold. A later frame with the hold request inactive is received from bit 7 with output driven.
- R11: `so_oe_o` is 1 exactly while the select is active and no hold is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| si_i | input | 1 | Serial data from the master |
| csn_i | input | 1 | Active-low select |
| holdn_i | input | 1 | Active-low hold request |
| tx_byte_i | input | 8 | Next byte to send, from the command layer |
| so_o | output | 1 | Serial data output bit |
| so_oe_o | output | 1 | Output driver enable (0 = high impedance) |
| rx_valid_o | output | 1 | One-cycle strobe: a full byte was received |
| rx_byte_o | output | 8 | Last received byte |
| frame_start_o | output | 1 | One-cycle pulse on select activation |
| abort_o | output | 1 | One-cycle pulse: select released mid-byte |

## Verification
The bench drives hold requests at both clock phases.
- If the phase qualification were missing, the driver would drop while the clock is still high, or it would come back during a high phase and then treat the first resumed falling edge as a data edge.
- With the clock idling high, the bench checks the leading falling edge. A design that shifts on it would send every byte one bit early.
- The bench aborts a byte after three bits. A design that keeps the bit position would misalign the following frame.
- The bench also releases the select in the middle of a hold. A design that leaves the hold set would never drive the next frame.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int SFE_NPINS = 4;

  typedef struct packed {
    logic sck;
    logic si;
    logic csn;
    logic holdn;
  } sfe_pins_t;

  localparam sfe_pins_t SFE_PINS_IDLE = '{sck: 1'b0, si: 1'b0, csn: 1'b1, holdn: 1'b1};
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sfe_hold_ctrl.sv
module sfe_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sck_lvl,
  input  logic holdn,
  output logic hold
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!sel)          hold_d = 1'b0;
    else if (!sck_lvl) hold_d = ~holdn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q;

  // R8: no entry into hold while clock is high
  a_r8_no_entry_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_lvl && !hold_q) |=> !hold_q);
  // R9: no release while clock is high and selected
  a_r9_no_exit_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_lvl && sel && hold_q) |=> hold_q);
  // R10: deselect clears hold
  a_r10_desel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !hold_q);
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         frame_start,
  input  logic         frame_end,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         hold,
  input  logic         si,
  input  logic [W-1:0] tx_byte,
  output logic         rx_valid,
  output logic [W-1:0] rx_byte,
  output logic         so_bit,
  output logic         abort
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     rx_sh_q, rx_sh_d, tx_sh_q, tx_sh_d, rx_byte_q, rx_byte_d;
  logic             armed_q, armed_d, valid_q, valid_d, abort_q, abort_d;
  logic             run;

  assign run = sel && !hold;

  always_comb begin
    cnt_d     = cnt_q;
    rx_sh_d   = rx_sh_q;
    tx_sh_d   = tx_sh_q;
    rx_byte_d = rx_byte_q;
    armed_d   = armed_q;
    valid_d   = 1'b0;
    abort_d   = 1'b0;
    if (frame_start) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      tx_sh_d = tx_byte;
    end else if (frame_end) begin
      abort_d = (cnt_q != '0);
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (run && sck_rise) begin
      rx_sh_d = {rx_sh_q[W-2:0], si};
      armed_d = 1'b1;
      if (cnt_q == LAST) begin
        cnt_d     = '0;
        valid_d   = 1'b1;
        rx_byte_d = {rx_sh_q[W-2:0], si};
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (run && sck_fall && armed_q) begin
      armed_d = 1'b0;
      if (cnt_q == '0) tx_sh_d = tx_byte;
      else             tx_sh_d = {tx_sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      rx_byte_q <= '0;
      armed_q   <= 1'b0;
      valid_q   <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      rx_sh_q   <= rx_sh_d;
      tx_sh_q   <= tx_sh_d;
      rx_byte_q <= rx_byte_d;
      armed_q   <= armed_d;
      valid_q   <= valid_d;
      abort_q   <= abort_d;
    end
  end

  assign rx_valid = valid_q;
  assign rx_byte  = rx_byte_q;
  assign so_bit   = tx_sh_q[W-1];
  assign abort    = abort_q;

  // R2: byte strobe lasts a single cycle
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R7: bit position frozen during hold
  a_r7_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && sel) |=> $stable(cnt_q));
  // R6: an aborted byte never also reports valid
  a_r6_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !rx_valid);
endmodule

// File: rtl/sfe_spi_frontend.sv
module sfe_spi_frontend
  import sfe_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_i,
  input  logic         si_i,
  input  logic         csn_i,
  input  logic         holdn_i,
  input  logic [W-1:0] tx_byte_i,
  output logic         so_o,
  output logic         so_oe_o,
  output logic         rx_valid_o,
  output logic [W-1:0] rx_byte_o,
  output logic         frame_start_o,
  output logic         abort_o
);
  logic      rst_ni;
  sfe_pins_t pins_raw, pins_s;
  logic      sck_q, sel_q, sel_s, hold;
  logic      sck_rise, sck_fall, frame_start, frame_end;

  sfe_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni));

  assign pins_raw = '{sck: sck_i, si: si_i, csn: csn_i, holdn: holdn_i};

  sfe_sync #(.W(SFE_NPINS), .STAGES(SYNC_STAGES), .RST_VAL(SFE_PINS_IDLE)) u_pin_sync (
    .clk(clk), .rst_n(rst_ni), .d(pins_raw), .q(pins_s));

  assign sel_s = ~pins_s.csn;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= pins_s.sck;
      sel_q <= sel_s;
    end
  end

  assign sck_rise    =  pins_s.sck & ~sck_q;
  assign sck_fall    = ~pins_s.sck &  sck_q;
  assign frame_start =  sel_s & ~sel_q;
  assign frame_end   = ~sel_s &  sel_q;

  sfe_hold_ctrl u_hold (
    .clk(clk), .rst_n(rst_ni), .sel(sel_s), .sck_lvl(pins_s.sck),
    .holdn(pins_s.holdn), .hold(hold));

  sfe_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .sel(sel_s), .frame_start(frame_start),
    .frame_end(frame_end), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .hold(hold), .si(pins_s.si), .tx_byte(tx_byte_i),
    .rx_valid(rx_valid_o), .rx_byte(rx_byte_o), .so_bit(so_o), .abort(abort_o));

  assign so_oe_o       = sel_s & ~hold;
  assign frame_start_o = frame_start;

  // R5: frame start is a single-cycle pulse
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  // R4: output bit moves only after a falling clock edge or a new frame
  a_r4_so_on_fall: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$past(sck_fall) && !$past(frame_start)) |-> $stable(so_o));
endmodule

// File: tb/sfe_spi_frontend_tb_top.sv
`timescale 1ns/1ps
module sfe_spi_frontend_tb_top;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, csn = 1'b1, holdn = 1'b1;
  logic [7:0] tx_byte;
  logic so, so_oe, rx_valid, fstart, abrt;
  logic [7:0] rx_byte;

  logic [7:0] tx_list [16];
  logic [7:0] rx_log [64];
  int rx_cnt = 0, ab_cnt = 0, fs_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sfe_spi_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .si_i(si), .csn_i(csn), .holdn_i(holdn),
    .tx_byte_i(tx_byte), .so_o(so), .so_oe_o(so_oe), .rx_valid_o(rx_valid),
    .rx_byte_o(rx_byte), .frame_start_o(fstart), .abort_o(abrt));

  assign tx_byte = tx_list[rx_cnt[3:0]];

  always @(posedge clk) begin
    if (rx_valid) begin
      rx_log[rx_cnt[5:0]] <= rx_byte;
      rx_cnt <= rx_cnt + 1;
    end
    if (abrt)   ab_cnt <= ab_cnt + 1;
    if (fstart) fs_cnt <= fs_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hk: 0 none, 1 hold entered/left in low phase, 2 entered/left in high phase
  task automatic xfer(input logic [7:0] mo, input int hk, input int hbit, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = mo[i]; w(H);
      if (hk == 1 && (7 - i) == hbit) begin
        holdn = 1'b0; w(4);
        chk(!so_oe, "R7 oe off in hold", so_oe, 0);
        si = ~mo[i]; sck = 1'b1; w(H); sck = 1'b0; w(H);
        chk(!so_oe, "R7 still held", so_oe, 0);
        holdn = 1'b1; w(4);
        chk(so_oe, "R7 oe back", so_oe, 1);
        si = mo[i]; w(H);
      end
      mi[i] = so;
      sck = 1'b1; w(H);
      if (hk == 2 && (7 - i) == hbit) begin
        holdn = 1'b0; w(4);
        chk(so_oe, "R8 entry deferred while high", so_oe, 1);
        sck = 1'b0; w(4);
        chk(!so_oe, "R8 entry at low phase", so_oe, 0);
        si = ~si; sck = 1'b1; w(H);
        holdn = 1'b1; w(4);
        chk(!so_oe, "R9 release deferred while high", so_oe, 0);
        sck = 1'b0; w(4);
        chk(so_oe, "R9 release at low phase", so_oe, 1);
        w(H);
      end
    end
  endtask

  task automatic frame(input bit idle_hi, input logic [7:0] mo [], input int hk, input int hbit, input string req);
    logic [7:0] mi;
    int base;
    base = rx_cnt;
    sck = idle_hi; w(H);
    csn = 1'b0; w(H);
    for (int b = 0; b < mo.size(); b++) begin
      xfer(mo[b], (b == 0) ? hk : 0, hbit, mi);
      chk(mi == tx_list[(base + b) % 16], {req, " tx R4"}, mi, tx_list[(base + b) % 16]);
    end
    if (!idle_hi) begin sck = 1'b0; w(H); end
    csn = 1'b1; w(H);
    chk(rx_cnt == base + mo.size(), {req, " byte count"}, rx_cnt - base, mo.size());
    for (int b = 0; b < mo.size(); b++)
      chk(rx_log[(base + b) % 64] == mo[b], {req, " rx byte"}, rx_log[(base + b) % 64], mo[b]);
  endtask

  task automatic t_reset();
    chk(!so_oe && !rx_valid && !fstart && !abrt, "R1 reset idle", {so_oe, rx_valid, fstart, abrt}, 0);
  endtask

  task automatic t_mode0();
    int f0;
    f0 = fs_cnt;
    frame(1'b0, '{8'h96, 8'h4B}, 0, 0, "R2 idle-low");
    chk(fs_cnt == f0 + 1, "R5 frame start pulse", fs_cnt - f0, 1);
  endtask

  task automatic t_mode3();
    frame(1'b1, '{8'hE1, 8'h27}, 0, 0, "R3 idle-high");
  endtask

  task automatic t_abort();
    int a0, r0;
    a0 = ab_cnt; r0 = rx_cnt;
    sck = 1'b0; csn = 1'b0; w(H);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; w(H); sck = 1'b1; w(H); sck = 1'b0;
    end
    w(H); csn = 1'b1; w(H);
    chk(ab_cnt == a0 + 1, "R6 abort pulse", ab_cnt - a0, 1);
    chk(rx_cnt == r0, "R6 no byte on abort", rx_cnt - r0, 0);
    chk(!so_oe, "R11 oe off when deselected", so_oe, 0);
    frame(1'b0, '{8'h5A}, 0, 0, "R6 realign");
  endtask

  task automatic t_hold_low();
    frame(1'b0, '{8'h3C, 8'hC3}, 1, 4, "R7 hold low phase");
  endtask

  task automatic t_hold_high();
    frame(1'b0, '{8'h71}, 2, 3, "R8 R9 hold high phase");
  endtask

  task automatic t_desel_hold();
    int a0;
    a0 = ab_cnt;
    sck = 1'b0; csn = 1'b0; w(H);
    si = 1'b1; w(H); sck = 1'b1; w(H); sck = 1'b0; w(H);
    holdn = 1'b0; w(4);
    chk(!so_oe, "R10 held before deselect", so_oe, 0);
    csn = 1'b1; w(6);
    chk(ab_cnt == a0 + 1, "R10 deselect in hold aborts", ab_cnt - a0, 1);
    holdn = 1'b1; w(H);
    csn = 1'b0; w(6);
    chk(so_oe, "R10 R11 driven after reselect", so_oe, 1);
    csn = 1'b1; w(H);
    frame(1'b0, '{8'h0F}, 0, 0, "R10 clean frame");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tx_list[i] = 8'(i * 37 + 8'hA5);
    w(3);
    t_reset();
    rst_n = 1'b1; w(6);
    t_reset();
    t_mode0();
    t_mode3();
    t_abort();
    t_hold_low();
    t_hold_high();
    t_desel_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule